// File: doc/BRIEF.md
# Interrupt Event Status Register

This block holds the interrupt event word of a serial-bus link controller. Single-cycle pulses from the link, the PHY and the DMA engines are caught in sticky status bits. Software reads the word and clears or sets bits through a small register bus. The bus has one address for reading, one for setting bits and one for clearing bits.

Two bits of the word are never stored. Each is computed live from a vector of per-context isochronous events and its mask vector. The self-ID bits interact with bus reset: a bus reset wipes the primary self-ID flag in the same edge, while a secondary copy of that flag survives until software clears it. An interrupt request is raised whenever a bit of the word meets a one in the enable-mask input.

Top module: `ies_irq_status`

## Requirements
- R1: Each event input pulse sets its latched bit at the next clock edge, visible in the following cycle. The bit positions are: bus reset 17, self-ID done 16 (and 15), lock error 9, posted-write error 8, response packet 5, request packet 4, receive-response DMA done 3, receive-request DMA done 2, transmit-response DMA done 1, transmit-request DMA done 0.
- R2: A bus reset pulse, or a set write with bit 17 at one, clears bit 16 at the same edge that sets bit 17. This overrides a concurrent self-ID pulse and a concurrent set of bit 16.
- R3: Bit 15 sets on every self-ID pulse, including one concurrent with a bus reset. Bus reset never changes it. Only a clear write with bit 15 at one lowers it.
- R4: Bits 31 to 18 and 14 to 10 always read zero, and writes to them have no effect.
- R5: Bit 7 reads as the OR of (receive context events AND receive masks), and bit 6 as the same for transmit. Both follow their inputs in the same cycle, are never stored, and are unaffected by set or clear writes.
- R6: Bus address 0 reads the word; writes to address 0 or 3 are ignored. A write to address 1 ORs the data into the latched bits. A write to address 2 clears the latched bits where the data is one. Zero data bits change nothing, and the read data is zero when the address is not 0.
- R7: When an event pulse and a clear write hit the same bit in one cycle, the bit ends up set.
- R8: `irq_out` is one exactly when (word AND `irq_en`) is nonzero. The word here includes the live bits 7 and 6, and the output responds combinationally.
- R9: While reset is asserted and right after it, every latched bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | 0 read, 1 set, 2 clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (word when address is 0) |
| evt_bus_reset | input | 1 | PHY entered bus reset |
| evt_selfid_done | input | 1 | Self-ID stream fully received |
| evt_lock_err | input | 1 | Lock response not acknowledged complete |
| evt_post_err | input | 1 | Host error posting an acknowledged write |
| evt_rsp_pkt | input | 1 | Packet placed in receive-response buffer |
| evt_req_pkt | input | 1 | Packet placed in receive-request buffer |
| evt_rsp_rx_done | input | 1 | Receive-response descriptor completed |
| evt_req_rx_done | input | 1 | Receive-request descriptor completed |
| evt_rsp_tx_done | input | 1 | Transmit-response descriptor completed |
| evt_req_tx_done | input | 1 | Transmit-request descriptor completed |
| iso_rx_evt | input | N_RX | Per-context isochronous receive events |
| iso_rx_msk | input | N_RX | Per-context isochronous receive masks |
| iso_tx_evt | input | N_TX | Per-context isochronous transmit events |
| iso_tx_msk | input | N_TX | Per-context isochronous transmit masks |
| irq_en | input | 32 | Interrupt enable mask |
| irq_out | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check four things. Reserved bits read zero. A bus reset leaves bit 17 set and bit 16 clear. Bit 15 survives anything except its own clear. A lock-error pulse beats a clear. They also check that the stored word holds still when there is neither a write nor an event, that a clear of bit 0 takes effect, that the live receive bit follows its vectors, and that a zero enable mask silences the request. Other behaviours need the bench's scenarios, which compare the full word against an independent model: the same-edge race between self-ID and bus reset, ignored writes to addresses 0 and 3, set writes that try to touch live or reserved bits, and the interrupt request under random enable masks.

// File: rtl/ies_pkg.sv
package ies_pkg;

    localparam int REG_W = 32;

    localparam int BIT_BUS_RST = 17;
    localparam int BIT_SID     = 16;
    localparam int BIT_SID2    = 15;
    localparam int BIT_LOCK    = 9;
    localparam int BIT_POST    = 8;
    localparam int BIT_ISO_RX  = 7;
    localparam int BIT_ISO_TX  = 6;
    localparam int BIT_RSP_PKT = 5;
    localparam int BIT_REQ_PKT = 4;
    localparam int BIT_RSP_RX  = 3;
    localparam int BIT_REQ_RX  = 2;
    localparam int BIT_RSP_TX  = 1;
    localparam int BIT_REQ_TX  = 0;

    // Bits held in flops; everything else is live or reads zero.
    localparam logic [REG_W-1:0] LATCH_MASK = 32'h0003_833F;

    typedef enum logic [1:0] {
        OP_STAT = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_NONE = 2'd3
    } bus_op_e;

endpackage

// File: rtl/ies_bus_decode.sv
module ies_bus_decode
    import ies_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  set_vec,
    output logic [REG_W-1:0]  clr_vec,
    output logic              rd_sel
);

    bus_op_e op;

    always_comb begin
        if (bus_addr == ADDR_W'(OP_STAT))
            op = OP_STAT;
        else if (bus_addr == ADDR_W'(OP_SET))
            op = OP_SET;
        else if (bus_addr == ADDR_W'(OP_CLR))
            op = OP_CLR;
        else
            op = OP_NONE;
    end

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        rd_sel  = 1'b0;
        unique case (op)
            OP_STAT: rd_sel = 1'b1;
            OP_SET:  if (bus_wr) set_vec = bus_wdata & LATCH_MASK;
            OP_CLR:  if (bus_wr) clr_vec = bus_wdata & LATCH_MASK;
            OP_NONE: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/ies_latch_bank.sv
module ies_latch_bank
    import ies_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_vec,
    input  logic [REG_W-1:0] set_vec,
    input  logic [REG_W-1:0] clr_vec,
    input  logic [REG_W-1:0] kill_vec,
    output logic [REG_W-1:0] stat_q
);

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        logic nxt;

        // Kill wins over everything; an event or set wins over a clear.
        always_comb begin
            if (kill_vec[i])
                nxt = 1'b0;
            else
                nxt = evt_vec[i] | set_vec[i] | (stat_q[i] & ~clr_vec[i]);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stat_q[i] <= 1'b0;
            else
                stat_q[i] <= LATCH_MASK[i] ? nxt : 1'b0;
        end
    end

endmodule

// File: rtl/ies_iso_reduce.sv
module ies_iso_reduce #(
    parameter int N_CTX = 4
) (
    input  logic [N_CTX-1:0] ctx_evt,
    input  logic [N_CTX-1:0] ctx_msk,
    output logic             any_hit
);

    logic [N_CTX-1:0] hit_v;

    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
        assign hit_v[c] = ctx_evt[c] & ctx_msk[c];
    end

    assign any_hit = |hit_v;

endmodule

// File: rtl/ies_irq_status.sv
module ies_irq_status
    import ies_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int N_RX   = 4,
    parameter int N_TX   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              evt_bus_reset,
    input  logic              evt_selfid_done,
    input  logic              evt_lock_err,
    input  logic              evt_post_err,
    input  logic              evt_rsp_pkt,
    input  logic              evt_req_pkt,
    input  logic              evt_rsp_rx_done,
    input  logic              evt_req_rx_done,
    input  logic              evt_rsp_tx_done,
    input  logic              evt_req_tx_done,
    input  logic [N_RX-1:0]   iso_rx_evt,
    input  logic [N_RX-1:0]   iso_rx_msk,
    input  logic [N_TX-1:0]   iso_tx_evt,
    input  logic [N_TX-1:0]   iso_tx_msk,
    input  logic [31:0]       irq_en,
    output logic              irq_out
);

    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] evt_vec;
    logic [REG_W-1:0] kill_vec;
    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] word;
    logic             rd_sel;
    logic             rx_live;
    logic             tx_live;

    ies_bus_decode #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .rd_sel    (rd_sel)
    );

    always_comb begin
        evt_vec              = '0;
        evt_vec[BIT_BUS_RST] = evt_bus_reset;
        evt_vec[BIT_SID]     = evt_selfid_done;
        evt_vec[BIT_SID2]    = evt_selfid_done;
        evt_vec[BIT_LOCK]    = evt_lock_err;
        evt_vec[BIT_POST]    = evt_post_err;
        evt_vec[BIT_RSP_PKT] = evt_rsp_pkt;
        evt_vec[BIT_REQ_PKT] = evt_req_pkt;
        evt_vec[BIT_RSP_RX]  = evt_rsp_rx_done;
        evt_vec[BIT_REQ_RX]  = evt_req_rx_done;
        evt_vec[BIT_RSP_TX]  = evt_rsp_tx_done;
        evt_vec[BIT_REQ_TX]  = evt_req_tx_done;
    end

    // Any request to raise bit 17 wipes the primary self-ID flag.
    always_comb begin
        kill_vec          = '0;
        kill_vec[BIT_SID] = evt_vec[BIT_BUS_RST] | set_vec[BIT_BUS_RST];
    end

    ies_latch_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_vec  (evt_vec),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .kill_vec (kill_vec),
        .stat_q   (stat_q)
    );

    ies_iso_reduce #(
        .N_CTX (N_RX)
    ) u_rx (
        .ctx_evt (iso_rx_evt),
        .ctx_msk (iso_rx_msk),
        .any_hit (rx_live)
    );

    ies_iso_reduce #(
        .N_CTX (N_TX)
    ) u_tx (
        .ctx_evt (iso_tx_evt),
        .ctx_msk (iso_tx_msk),
        .any_hit (tx_live)
    );

    always_comb begin
        word             = stat_q;
        word[BIT_ISO_RX] = rx_live;
        word[BIT_ISO_TX] = tx_live;
    end

    assign bus_rdata = rd_sel ? word : '0;
    assign irq_out   = |(word & irq_en);

endmodule

// File: rtl/ies_checker.sv
module ies_checker #(
    parameter int ADDR_W = 2,
    parameter int N_RX   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       stat_q,
    input logic              evt_bus_reset,
    input logic              evt_selfid_done,
    input logic              evt_lock_err,
    input logic              evt_post_err,
    input logic              evt_rsp_pkt,
    input logic              evt_req_pkt,
    input logic              evt_rsp_rx_done,
    input logic              evt_req_rx_done,
    input logic              evt_rsp_tx_done,
    input logic              evt_req_tx_done,
    input logic [N_RX-1:0]   iso_rx_evt,
    input logic [N_RX-1:0]   iso_rx_msk,
    input logic [31:0]       irq_en,
    input logic              irq_out
);

    logic any_evt;
    logic clr_wr;

    assign any_evt = evt_bus_reset | evt_selfid_done | evt_lock_err | evt_post_err |
                     evt_rsp_pkt | evt_req_pkt | evt_rsp_rx_done | evt_req_rx_done |
                     evt_rsp_tx_done | evt_req_tx_done;
    assign clr_wr  = bus_wr && (bus_addr == ADDR_W'(2));

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[31:18] == '0) && (bus_rdata[14:10] == '0)); // R4

    AST_BUSRST_DROPS_SID: assert property (@(posedge clk) disable iff (!rst_n)
        evt_bus_reset |=> (stat_q[17] && !stat_q[16])); // R2

    AST_SID2_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[15] && !(clr_wr && bus_wdata[15])) |=> stat_q[15]); // R3

    AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        evt_lock_err |=> stat_q[9]); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !any_evt) |=> $stable(stat_q)); // R6

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && bus_wdata[0] && !evt_req_tx_done) |=> !stat_q[0]); // R6

    AST_LIVE_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata[7] == |(iso_rx_evt & iso_rx_msk))); // R5

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq_out); // R8

endmodule

bind ies_irq_status ies_checker #(
    .ADDR_W (ADDR_W),
    .N_RX   (N_RX)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_wr          (bus_wr),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .stat_q          (stat_q),
    .evt_bus_reset   (evt_bus_reset),
    .evt_selfid_done (evt_selfid_done),
    .evt_lock_err    (evt_lock_err),
    .evt_post_err    (evt_post_err),
    .evt_rsp_pkt     (evt_rsp_pkt),
    .evt_req_pkt     (evt_req_pkt),
    .evt_rsp_rx_done (evt_rsp_rx_done),
    .evt_req_rx_done (evt_req_rx_done),
    .evt_rsp_tx_done (evt_rsp_tx_done),
    .evt_req_tx_done (evt_req_tx_done),
    .iso_rx_evt      (iso_rx_evt),
    .iso_rx_msk      (iso_rx_msk),
    .irq_en          (irq_en),
    .irq_out         (irq_out)
);

// File: tb/tb_ies_irq_status.sv
module tb_ies_irq_status;

    localparam int ADDR_W = 2;
    localparam int N_RX   = 4;
    localparam int N_TX   = 4;
    localparam logic [31:0] LM = 32'h0003_833F;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [9:0]        ev = '0;
    logic [N_RX-1:0]   iso_rx_evt = '0;
    logic [N_RX-1:0]   iso_rx_msk = '0;
    logic [N_TX-1:0]   iso_tx_evt = '0;
    logic [N_TX-1:0]   iso_tx_msk = '0;
    logic [31:0]       irq_en = '0;
    logic              irq_out;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [31:0] exp_q = '0;

    always #4 clk = ~clk;

    ies_irq_status #(.ADDR_W(ADDR_W), .N_RX(N_RX), .N_TX(N_TX)) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_wr          (bus_wr),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .evt_bus_reset   (ev[9]),
        .evt_selfid_done (ev[8]),
        .evt_lock_err    (ev[7]),
        .evt_post_err    (ev[6]),
        .evt_rsp_pkt     (ev[5]),
        .evt_req_pkt     (ev[4]),
        .evt_rsp_rx_done (ev[3]),
        .evt_req_rx_done (ev[2]),
        .evt_rsp_tx_done (ev[1]),
        .evt_req_tx_done (ev[0]),
        .iso_rx_evt      (iso_rx_evt),
        .iso_rx_msk      (iso_rx_msk),
        .iso_tx_evt      (iso_tx_evt),
        .iso_tx_msk      (iso_tx_msk),
        .irq_en          (irq_en),
        .irq_out         (irq_out)
    );

    function automatic logic [31:0] ev_map(input logic [9:0] e);
        logic [31:0] v;
        v = '0;
        v[5:0] = e[5:0];
        v[8]   = e[6];
        v[9]   = e[7];
        v[16]  = e[8];
        v[15]  = e[8];
        v[17]  = e[9];
        return v;
    endfunction

    function automatic logic [31:0] model_next(input logic [31:0] cur, input logic [9:0] e,
                                               input logic wr, input logic [1:0] a,
                                               input logic [31:0] wd);
        logic [31:0] s, c, n;
        s = (wr && a == 2'd1) ? (wd & LM) : '0;
        c = (wr && a == 2'd2) ? (wd & LM) : '0;
        n = ev_map(e) | s | (cur & ~c);
        if (e[9] || s[17]) n[16] = 1'b0;
        return n & LM;
    endfunction

    function automatic logic [31:0] live_word(input logic [31:0] q);
        logic [31:0] w;
        w = q;
        w[7] = |(iso_rx_evt & iso_rx_msk);
        w[6] = |(iso_tx_evt & iso_tx_msk);
        return w;
    endfunction

    task automatic check32(input string tag, input logic [31:0] got, input logic [31:0] expv);
        n_chk++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, expv);
        end
    endtask

    task automatic check_word(input string tag);
        logic [31:0] w;
        w = live_word(exp_q);
        check32(tag, bus_rdata, w);
        check32({tag, " irq R8"}, {31'd0, irq_out}, {31'd0, |(w & irq_en)});
    endtask

    // One bus/event cycle, then idle read-back and compare.
    task automatic step(input string tag, input logic [9:0] e, input logic wr,
                        input logic [1:0] a, input logic [31:0] wd);
        @(negedge clk);
        ev = e; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        @(posedge clk);
        exp_q = model_next(exp_q, e, wr, a, wd);
        #1;
        ev = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        #1;
        check_word(tag);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        void'($urandom(32'd1234));
        irq_en = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check32("R9 reset rdata", bus_rdata, 32'h0);
        check32("R9 reset irq", {31'd0, irq_out}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_word("R9 after reset");

        for (int i = 0; i < 10; i++)
            step($sformatf("R1 event %0d", i), 10'(1 << i), 1'b0, 2'd0, 32'h0);
        step("R6 clear all", '0, 1'b1, 2'd2, 32'hFFFF_FFFF);
        check32("R6 cleared", bus_rdata, 32'h0);

        step("R4 R2 set all", '0, 1'b1, 2'd1, 32'hFFFF_FFFF);
        check32("R4 R2 set all word", bus_rdata, 32'h0002_833F);
        step("R6 clear zeros no effect", '0, 1'b1, 2'd2, 32'h0);
        step("R6 clear all 2", '0, 1'b1, 2'd2, 32'hFFFF_FFFF);

        step("R1 self-ID", 10'h100, 1'b0, 2'd0, 32'h0);
        check32("R1 R3 sid bits", bus_rdata, 32'h0001_8000);
        step("R2 R3 bus reset", 10'h200, 1'b0, 2'd0, 32'h0);
        check32("R2 R3 after reset", bus_rdata, 32'h0002_8000);
        step("R3 clear bit15", '0, 1'b1, 2'd2, 32'h0000_8000);
        check32("R3 bit15 cleared", bus_rdata, 32'h0002_0000);
        step("R2 R3 reset plus sid", 10'h300, 1'b0, 2'd0, 32'h0);
        check32("R2 R3 same edge", bus_rdata, 32'h0002_8000);
        step("R6 clear all 3", '0, 1'b1, 2'd2, 32'hFFFF_FFFF);

        step("R7 set bit9", 10'h080, 1'b0, 2'd0, 32'h0);
        step("R7 clear vs event", 10'h080, 1'b1, 2'd2, 32'h0000_0200);
        check32("R7 bit9 kept", bus_rdata, 32'h0000_0200);

        step("R6 write addr0 ignored", '0, 1'b1, 2'd0, 32'hFFFF_FFFF);
        step("R6 write addr3 ignored", '0, 1'b1, 2'd3, 32'hFFFF_FFFF);
        check32("R6 ignored writes", bus_rdata, 32'h0000_0200);
        @(negedge clk);
        bus_addr = 2'd1;
        #1;
        check32("R6 rdata off address", bus_rdata, 32'h0);
        bus_addr = 2'd0;

        @(negedge clk);
        iso_rx_evt = 4'b0101; iso_rx_msk = 4'b1010;
        #1;
        check32("R5 rx masked off", bus_rdata & 32'hC0, 32'h0);
        iso_rx_msk = 4'b0100;
        #1;
        check32("R5 rx live", bus_rdata & 32'hC0, 32'h80);
        step("R5 set live bits", '0, 1'b1, 2'd1, 32'h0000_00C0);
        check32("R5 set has no effect", bus_rdata, 32'h0000_0280);
        irq_en = 32'h0000_0080;
        #1;
        check32("R8 irq from live", {31'd0, irq_out}, 32'h1);
        iso_rx_evt = '0;
        #1;
        check32("R8 irq drops", {31'd0, irq_out}, 32'h0);

        for (int k = 0; k < 3000; k++) begin
            logic [9:0] e;
            for (int b = 0; b < 10; b++) e[b] = ($urandom % 8) == 0;
            iso_rx_evt = 4'($urandom); iso_rx_msk = 4'($urandom);
            iso_tx_evt = 4'($urandom); iso_tx_msk = 4'($urandom);
            irq_en     = ($urandom % 4 == 0) ? 32'h0 : $urandom;
            step("R1 R6 random", e, ($urandom % 3) == 0, 2'($urandom), $urandom);
        end

        finish_up();
    end

endmodule